// File: doc/BRIEF.md
# Race-Timed Global Sequence Alignment Engine

This block scores the global alignment of two short DNA strings without any adder. Every score is a time. On an accepted start strobe, a single pulse enters the top-left corner of a grid of (LEN+1) by (LEN+1) cells. It then spreads through the grid one clock at a time. Each cell latches the first pulse that reaches it. Because a cell takes the earliest of its three inputs, a plain OR forms the minimum. Because each unit of cost is one register on the path, a chain of flip-flops forms the addition.

A step to the right or a step down stands for a gap and costs one cycle. A diagonal step where the two bases are equal passes straight through in the same cycle, with no register. A diagonal step where the bases differ goes through two registers. A free-running counter starts at zero on the accepted start. When the bottom-right cell fires, the counter value is stored as the score and a one-cycle done pulse is raised. Both sequences are captured at the start, so the inputs are free to change during a run.

Top module: `race_align_engine`

## Requirements
- R1: After reset, `done_o` is 0 and `score_o` is 0.
- R2: A base is 2 bits: A=00, C=01, G=10, T=11. Symbol k of `query_i` is bits [2k+1:2k] and indexes the grid rows. Symbol k of `ref_i` is bits [2k+1:2k] and indexes the grid columns.
- R3: The block accepts `start_i` while it is idle. The rising edge that samples it counts as cycle 0. If the final score is S, `done_o` is first high after rising edge S+1.
- R4: `score_o` equals the minimum global alignment cost, where a gap costs 1, a matching pair costs 0 and a mismatching pair costs 2. Once a cell has fired, inputs that arrive later do not change it.
- R5: Two sequences with no base in common score 2*LEN. With the default LEN this is 40.
- R6: `done_o` stays high for exactly one cycle. `score_o` keeps its value until the next run completes.
- R7: A `start_i` that arrives during a run is ignored. The run goes on and reports the score of the sequences it captured.
- R8: Changes to `query_i` and `ref_i` after an accepted start have no effect on that run.
- R9: An accepted start clears every cell. A new run therefore produces its own score, whatever the previous run left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a run; has an effect only while idle |
| query_i | input | 2*LEN | Query string, 2 bits per base, symbol 0 in the low bits |
| ref_i | input | 2*LEN | Reference string, same packing |
| done_o | output | 1 | One-cycle pulse when the score is valid |
| score_o | output | CNT_W | Alignment cost, held between runs |

## Verification
The assertions rely on two facts about the inputs. First, `start_i` is a clean synchronous level. Second, the strings are stable at the edge that accepts a start. Under those conditions, the pulse reaches the last cell within 2*LEN cycles, and the counter bound holds. The bench drives every input on the falling edge, so this condition is always met. It also keeps each start strobe to one cycle, except for a deliberate second strobe raised during a run. That second strobe comes with altered strings, to show that it is ignored.

// File: rtl/race_pkg.sv
package race_pkg;
  localparam int SYM_W = 2;

  typedef enum logic [SYM_W-1:0] {
    BASE_A = 2'b00,
    BASE_C = 2'b01,
    BASE_G = 2'b10,
    BASE_T = 2'b11
  } base_t;
endpackage

// File: rtl/race_cell.sv
module race_cell #(
  parameter bit IS_ORIGIN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic match_i,
  input  logic up_i,
  input  logic left_i,
  input  logic diag_i,
  output logic arrive_o
);
  logic fired_q;
  logic slow_q;

  // Matching diagonal passes with no register; otherwise the cell shows its latch.
  assign arrive_o = fired_q | (match_i & diag_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      fired_q <= 1'b0;
      slow_q  <= 1'b0;
    end else if (clear_i) begin
      fired_q <= IS_ORIGIN;
      slow_q  <= 1'b0;
    end else begin
      slow_q  <= diag_i & ~match_i;
      fired_q <= fired_q | up_i | left_i | slow_q;
    end
  end

  // Once fired, a cell stays fired until the next clear (R4).
  assert_latch_held_R4: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !clear_i) |=> fired_q);
endmodule

// File: rtl/race_ctrl.sv
module race_ctrl #(
  parameter int LEN   = 20,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             final_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] score_o
);
  localparam int MAX_SCORE = 2 * LEN;

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] score_q;

  assign accept_o = start_i & ~busy_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign score_o  = score_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      score_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (final_i) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          score_q <= cnt_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_score_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i) |=> $stable(score_q));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !final_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(cnt_q) <= MAX_SCORE));

  assert_score_bound_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (int'(score_q) <= MAX_SCORE));
endmodule

// File: rtl/race_align_engine.sv
module race_align_engine #(
  parameter int LEN   = 20,
  localparam int SEQ_W = race_pkg::SYM_W * LEN,
  localparam int CNT_W = $clog2(2 * LEN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SEQ_W-1:0] query_i,
  input  logic [SEQ_W-1:0] ref_i,
  output logic             done_o,
  output logic [CNT_W-1:0] score_o
);
  import race_pkg::*;

  localparam int GRID = LEN + 1;

  logic             accept;
  logic             busy;
  logic [SEQ_W-1:0] q_seq_q;
  logic [SEQ_W-1:0] r_seq_q;
  logic             arrive [0:GRID-1][0:GRID-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_seq_q <= '0;
      r_seq_q <= '0;
    end else if (accept) begin
      q_seq_q <= query_i;
      r_seq_q <= ref_i;
    end
  end

  for (genvar i = 0; i < GRID; i++) begin : g_row
    for (genvar j = 0; j < GRID; j++) begin : g_col
      logic up_w, left_w, diag_w, match_w;

      if (i > 0) begin : g_up
        assign up_w = arrive[i-1][j];
      end else begin : g_no_up
        assign up_w = 1'b0;
      end

      if (j > 0) begin : g_left
        assign left_w = arrive[i][j-1];
      end else begin : g_no_left
        assign left_w = 1'b0;
      end

      if (i > 0 && j > 0) begin : g_diag
        base_t q_base, r_base;
        assign q_base  = base_t'(q_seq_q[SYM_W*(i-1) +: SYM_W]);
        assign r_base  = base_t'(r_seq_q[SYM_W*(j-1) +: SYM_W]);
        assign match_w = (q_base == r_base);
        assign diag_w  = arrive[i-1][j-1];
      end else begin : g_no_diag
        assign match_w = 1'b0;
        assign diag_w  = 1'b0;
      end

      race_cell #(
        .IS_ORIGIN((i == 0) && (j == 0))
      ) cell_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .match_i (match_w),
        .up_i    (up_w),
        .left_i  (left_w),
        .diag_i  (diag_w),
        .arrive_o(arrive[i][j])
      );
    end
  end

  race_ctrl #(
    .LEN  (LEN),
    .CNT_W(CNT_W)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .final_i (arrive[LEN][LEN]),
    .accept_o(accept),
    .busy_o  (busy),
    .done_o  (done_o),
    .score_o (score_o)
  );

  // The corner cell fires in the cycle right after an accepted start (R9).
  assert_origin_seed_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> arrive[0][0]);

  // Captured strings stay put while a run is in progress (R8).
  assert_seq_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> ($stable(q_seq_q) && $stable(r_seq_q)));
endmodule

// File: tb/race_align_engine_tb_top.sv
module race_align_engine_tb_top;
  localparam int LEN   = 20;
  localparam int SEQ_W = 2 * LEN;
  localparam int CNT_W = $clog2(2 * LEN + 2);
  localparam int NV    = 7;

  typedef struct packed {
    logic [SEQ_W-1:0] q;
    logic [SEQ_W-1:0] r;
    logic [7:0]       exp;
  } vec_t;

  // Symbol k sits in bits [2k+1:2k]; A=00 C=01 G=10 T=11 (R2)
  localparam vec_t VECS [NV] = '{
    '{40'h0000000000, 40'h0000000000, 8'd0},   // identical all A
    '{40'h0000000000, 40'h5555555555, 8'd40},  // A vs C everywhere (R5)
    '{40'h0000000000, 40'hC000000000, 8'd2},   // last base differs
    '{40'hAAAAAAAAAA, 40'hFFFFFFFFFF, 8'd40},  // G vs T everywhere (R5)
    '{40'hE4E4E4E4E4, 40'h3939393939, 8'd2},   // ACGT.. vs CGTA.. shift
    '{40'h0000000002, 40'h0000000002, 8'd0},   // G at symbol 0 both (R2)
    '{40'h0000000002, 40'h0000000001, 8'd2}    // G vs C at symbol 0 (R2)
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [SEQ_W-1:0] query = '0;
  logic [SEQ_W-1:0] refseq = '0;
  logic             done;
  logic [CNT_W-1:0] score;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  race_align_engine #(.LEN(LEN)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .query_i(query),
    .ref_i  (refseq),
    .done_o (done),
    .score_o(score)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [SEQ_W-1:0] q, input logic [SEQ_W-1:0] r);
    int d [0:LEN][0:LEN];
    for (int i = 0; i <= LEN; i++) d[i][0] = i;
    for (int j = 0; j <= LEN; j++) d[0][j] = j;
    for (int i = 1; i <= LEN; i++) begin
      for (int j = 1; j <= LEN; j++) begin
        int best;
        best = d[i-1][j-1] + ((q[2*(i-1) +: 2] == r[2*(j-1) +: 2]) ? 0 : 2);
        if (d[i-1][j] + 1 < best) best = d[i-1][j] + 1;
        if (d[i][j-1] + 1 < best) best = d[i][j-1] + 1;
        d[i][j] = best;
      end
    end
    return d[LEN][LEN];
  endfunction

  // Drives start for one cycle; returns at the first falling edge after the accepting edge (k=1).
  task automatic launch(input logic [SEQ_W-1:0] q, input logic [SEQ_W-1:0] r);
    query  = q;
    refseq = r;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // k counts falling edges since the accepting edge; done expected at k = S+2
  task automatic wait_done(inout int k);
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run(input logic [SEQ_W-1:0] q, input logic [SEQ_W-1:0] r,
                     input int exp, input string req);
    int k;
    k = 1;
    launch(q, r);
    wait_done(k);
    check(done && int'(score) == exp, req, int'(score), exp);
    check(k == exp + 2, "R3 latency", k, exp + 2);
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    check(int'(score) == exp, "R6 score held", int'(score), exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] lf;
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(score == '0, "R1 score after reset", int'(score), 0);

    // Table of hand-worked vectors (R4, R5, R2)
    for (int v = 0; v < NV; v++) begin
      run(VECS[v].q, VECS[v].r, int'(VECS[v].exp), "R4 table score");
      repeat (2) @(negedge clk);
    end

    // Pseudo-random strings against the cost model (R4)
    lf = 64'h9E3779B97F4A7C15;
    for (int t = 0; t < 8; t++) begin
      logic [SEQ_W-1:0] q, r;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
      q = lf[SEQ_W-1:0];
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
      r = (t % 2 == 0) ? (q ^ (lf[SEQ_W-1:0] & lf[63:24])) : lf[SEQ_W-1:0];
      run(q, r, model(q, r), "R4 random score");
    end

    // R7 and R8: a second start with altered strings during a run is ignored
    k = 1;
    launch(40'h0000000000, 40'h5555555555);
    repeat (4) begin @(negedge clk); k++; end
    query  = 40'h1234512345;
    refseq = 40'h1234512345;
    start  = 1'b1;
    @(negedge clk); k++;
    start = 1'b0;
    repeat (3) begin @(negedge clk); k++; end
    query  = 40'hFFFFFFFFFF;
    wait_done(k);
    check(done && int'(score) == 40, "R7 busy start ignored", int'(score), 40);
    check(k == 42, "R8 captured strings kept", k, 42);
    @(negedge clk);

    // R9: a fresh run after a completed one starts from a cleared grid
    run(40'hE4E4E4E4E4, 40'hE4E4E4E4E4, 0, "R9 fresh run after full grid");
    run(40'h0000000000, 40'h5555555555, 40, "R9 rerun all mismatch");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule